// File: doc/BRIEF.md
# Two-Tier Resident Page List Manager

This block keeps track of which page numbers are resident and decides what happens on each page access. Resident pages sit in one of two lists. The active list holds pages that may be read and written at full speed. The second-chance list holds pages that are still in memory but are marked inaccessible, so any touch of one of them traps. Pages enter the active list at its front and leave it in arrival order. A page pushed out of the active list goes to the front of the second-chance list. A page that drops off the tail of the second-chance list, the one unused for longest, is written out.

Each access presents a page number. One registered cycle later the block reports the outcome as a 2-bit code. It also gives the page number to write out whenever a page-in forces an eviction. Both lists are small fully associative tag arrays whose depths are parameters. Both are searched in the same cycle, and one access can be accepted on every clock. If the second-chance depth is set to zero, the block behaves as a plain first-in first-out replacer.

Top module: `page_list_mgr`

## Requirements
- R1: A synchronous active-low reset empties both lists and clears `res_valid` and `evict_page`. The first access to any page after reset reports code 2.
- R2: An access to a page on the active list reports code 0 (hit) and changes neither list or its order.
- R3: When the page is on neither list and the active list is not full, the access reports code 2. The page is placed at the front of the active list.
- R4: When the page is on neither list and the active list is full, the oldest active page moves to the front of the second-chance list. A later access to that page reports code 1.
- R5: An access to a page on the second-chance list reports code 1 (refill). The page is taken out of that list and put at the front of the active list. If the active list was full, its oldest page moves to the front of the second-chance list in the same cycle. The next access to the refilled page reports code 0.
- R6: In the R4 case, if the second-chance list is also full, its tail page is evicted. The access then reports code 3 and drives that page on `evict_page`. With every other code, and in idle cycles, `evict_page` reads zero.
- R7: The second-chance list evicts in least-recently-demoted order. A refill removes its page from the middle of the list and leaves the relative order of the other pages unchanged.
- R8: No page number is ever on both lists at once.
- R9: An access presented with `acc_valid` high in one cycle gives `res_valid` high in the next cycle, and accesses may be back to back. In a cycle after no access, `res_valid` is low.
- R10: With a second-chance depth of 0, code 1 never occurs. A miss on a full active list reports code 3 and evicts the oldest active page, as first-in first-out replacement does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_page | input | PAGE_W | Page number being accessed |
| res_valid | output | 1 | Result for the access presented in the previous cycle |
| res_code | output | 2 | 0 hit, 1 refill from second-chance, 2 page-in, 3 page-in with eviction |
| evict_page | output | PAGE_W | Page to write out; meaningful only with code 3, zero otherwise |

## Verification
The bench goes after the case where a refill and a demotion land on the second-chance list in the same cycle. A design that shifted the wrong slice would lose a page or duplicate one, and a later eviction would then name the wrong page. It also removes pages from the head, the middle and the tail of the second-chance list and then drives the list to eviction, because an off-by-one in the compaction shows up as an evicted page out of order. A second instance with no second-chance list checks that the zero-depth variant degrades to first-in first-out and never reports a refill. A mid-run reset checks that previously resident pages come back as plain page-ins.

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
// plm_pkg: result codes shared by the page list manager and its bench.
package plm_pkg;
    typedef enum logic [1:0] {
        RC_HIT          = 2'd0,
        RC_REFILL       = 2'd1,
        RC_PAGEIN       = 2'd2,
        RC_PAGEIN_EVICT = 2'd3
    } plm_code_e;
endpackage

// File: rtl/plist_match.sv
`timescale 1ns/1ps
// plist_match: parallel tag compare of one key against every slot of a list.
// Assumes slot valid bits qualify the stored tags; output is one-hot or zero
// as long as the owning list never stores a tag twice.
module plist_match #(
    parameter int DEPTH  = 4,
    parameter int PAGE_W = 8
) (
    input  logic [DEPTH-1:0][PAGE_W-1:0] tags,
    input  logic [DEPTH-1:0]             vld,
    input  logic [PAGE_W-1:0]            key,
    output logic [DEPTH-1:0]             hit
);
    // one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = vld[g] && (tags[g] == key);
    end
endmodule

// File: rtl/plist_active.sv
`timescale 1ns/1ps
// plist_active: arrival-ordered active list. Slot 0 is the newest page and
// the highest valid slot the oldest. A push shifts every slot back by one,
// and when the list is full the oldest page falls off. The owner reads it
// from the last slot before pushing.
module plist_active #(
    parameter int DEPTH  = 4,
    parameter int PAGE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [PAGE_W-1:0]            push_page,
    output logic [DEPTH-1:0][PAGE_W-1:0] pages,
    output logic [DEPTH-1:0]             valid
);
    // shift-in register chain for tags and valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            pages <= '0;
        end else if (push) begin
            pages[0] <= push_page;
            valid[0] <= 1'b1;
            for (int j = 1; j < DEPTH; j++) begin
                pages[j] <= pages[j-1];
                valid[j] <= valid[j-1];
            end
        end
    end

    // valid slots stay packed toward slot 0
    assert_act_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid & (valid + 1'b1)) == '0));
endmodule

// File: rtl/plist_second.sv
`timescale 1ns/1ps
// plist_second: second-chance list. Slot 0 is the most recently demoted page
// and the highest valid slot is the least recently demoted one, the next to
// be evicted. It supports removing one slot (given one-hot) and pushing at
// the front in the same cycle. Assumes a push together with a full list and
// no removal drops the tail; the owner has already reported that page.
module plist_second #(
    parameter int DEPTH  = 3,
    parameter int PAGE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [PAGE_W-1:0]            push_page,
    input  logic                         remove,
    input  logic [DEPTH-1:0]             remove_sel,
    output logic [DEPTH-1:0][PAGE_W-1:0] pages,
    output logic [DEPTH-1:0]             valid
);
    logic [DEPTH-1:0][PAGE_W-1:0] pages_d;
    logic [DEPTH-1:0]             valid_d;
    int                           ridx;

    // index of the slot being removed
    always_comb begin
        ridx = 0;
        for (int j = 0; j < DEPTH; j++)
            if (remove_sel[j]) ridx = j;
    end

    // next-state: remove, push, or both, keeping the order of the others
    always_comb begin
        pages_d = pages;
        valid_d = valid;
        if (remove && push) begin
            pages_d[0] = push_page;
            valid_d[0] = 1'b1;
            for (int j = 1; j < DEPTH; j++) begin
                if (j <= ridx) begin
                    pages_d[j] = pages[j-1];
                    valid_d[j] = valid[j-1];
                end
            end
        end else if (remove) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j >= ridx) begin
                    if (j < DEPTH - 1) begin
                        pages_d[j] = pages[(j < DEPTH - 1) ? j + 1 : j];
                        valid_d[j] = valid[(j < DEPTH - 1) ? j + 1 : j];
                    end else begin
                        valid_d[j] = 1'b0;
                    end
                end
            end
        end else if (push) begin
            pages_d[0] = push_page;
            valid_d[0] = 1'b1;
            for (int j = 1; j < DEPTH; j++) begin
                pages_d[j] = pages[j-1];
                valid_d[j] = valid[j-1];
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            pages <= '0;
        end else begin
            valid <= valid_d;
            pages <= pages_d;
        end
    end

    // list stays packed toward the front, so the tail is the LRU victim
    assert_sc_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid & (valid + 1'b1)) == '0));
    // a removal targets an occupied slot
    assert_sc_remove_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        remove |-> ((remove_sel & valid) != '0));
endmodule

// File: rtl/page_list_mgr.sv
`timescale 1ns/1ps
// page_list_mgr: classifies each page access against an active list and a
// second-chance list, updates both lists and registers a result code (and
// eviction page) one cycle later. Assumes page numbers are plain tags; no
// memory transfer or permission bits are handled here. SC_DEPTH may be 0.
module page_list_mgr
    import plm_pkg::*;
#(
    parameter int ACT_DEPTH = 4,
    parameter int SC_DEPTH  = 3,
    parameter int PAGE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [PAGE_W-1:0] acc_page,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic [PAGE_W-1:0] evict_page
);
    localparam int  SCN    = (SC_DEPTH > 0) ? SC_DEPTH : 1;
    localparam bit  HAS_SC = (SC_DEPTH > 0);

    logic [ACT_DEPTH-1:0][PAGE_W-1:0] a_pages;
    logic [ACT_DEPTH-1:0]             a_valid;
    logic [ACT_DEPTH-1:0]             a_match;
    logic [SCN-1:0][PAGE_W-1:0]       s_pages;
    logic [SCN-1:0]                   s_valid;
    logic [SCN-1:0]                   s_match;
    logic a_hit, s_hit, a_full, s_full, a_push, demote, s_remove;
    plm_code_e         code_d;
    logic [PAGE_W-1:0] victim_d;

    // active list and its lookup
    plist_active #(.DEPTH(ACT_DEPTH), .PAGE_W(PAGE_W)) u_active (
        .clk(clk), .rst_n(rst_n), .push(a_push), .push_page(acc_page),
        .pages(a_pages), .valid(a_valid)
    );
    plist_match #(.DEPTH(ACT_DEPTH), .PAGE_W(PAGE_W)) u_amatch (
        .tags(a_pages), .vld(a_valid), .key(acc_page), .hit(a_match)
    );

    // second-chance list only when it has depth
    if (HAS_SC) begin : g_sc
        plist_second #(.DEPTH(SCN), .PAGE_W(PAGE_W)) u_second (
            .clk(clk), .rst_n(rst_n), .push(demote),
            .push_page(a_pages[ACT_DEPTH-1]), .remove(s_remove),
            .remove_sel(s_match), .pages(s_pages), .valid(s_valid)
        );
        plist_match #(.DEPTH(SCN), .PAGE_W(PAGE_W)) u_smatch (
            .tags(s_pages), .vld(s_valid), .key(acc_page), .hit(s_match)
        );
    end else begin : g_nosc
        assign s_pages = '0;
        assign s_valid = '0;
        assign s_match = '0;
    end

    // classify the access and derive list controls
    always_comb begin
        a_hit    = |a_match;
        s_hit    = |s_match;
        a_full   = a_valid[ACT_DEPTH-1];
        s_full   = HAS_SC && s_valid[SCN-1];
        a_push   = acc_valid && !a_hit;
        demote   = HAS_SC && a_push && a_full;
        s_remove = acc_valid && !a_hit && s_hit;
        victim_d = HAS_SC ? s_pages[SCN-1] : a_pages[ACT_DEPTH-1];
        if (a_hit)                               code_d = RC_HIT;
        else if (s_hit)                          code_d = RC_REFILL;
        else if (a_full && (!HAS_SC || s_full))  code_d = RC_PAGEIN_EVICT;
        else                                     code_d = RC_PAGEIN;
    end

    // result register, one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_code   <= 2'd0;
            evict_page <= '0;
        end else begin
            res_valid  <= acc_valid;
            if (acc_valid) res_code <= code_d;
            evict_page <= (acc_valid && code_d == RC_PAGEIN_EVICT) ? victim_d : '0;
        end
    end

    // cross-list duplicate detector for the invariant below
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < ACT_DEPTH; i++)
            for (int j = 0; j < SCN; j++)
                if (a_valid[i] && s_valid[j] && a_pages[i] == s_pages[j]) dup = 1'b1;
    end

    assert_no_dup_R8: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (a_valid == '0 && s_valid == '0 && !res_valid));

    assert_hit_keeps_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'd0) |->
            (a_pages == $past(a_pages) && a_valid == $past(a_valid)
             && s_valid == $past(s_valid)));

    assert_new_page_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code != 2'd0) |-> (a_valid[0] && a_pages[0] == $past(acc_page)));

    assert_evict_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'd3) |-> $past(a_full));

    assert_refill_had_sc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 2'd1) |-> ($past(s_valid) != '0));

    assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
endmodule

// File: tb/page_list_mgr_bench.sv
`timescale 1ns/1ps
// page_list_mgr_bench: behavioural queue model compared with two instances,
// one with a second-chance list and one with none.
module page_list_mgr_bench;
    localparam int NA = 4;
    localparam int NS = 3;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [PW-1:0] acc_page = '0;
    logic          rv0, rv1;
    logic [1:0]    rc0, rc1;
    logic [PW-1:0] ev0, ev1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    page_list_mgr #(.ACT_DEPTH(NA), .SC_DEPTH(NS), .PAGE_W(PW)) u_page_list_mgr (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .res_valid(rv0), .res_code(rc0), .evict_page(ev0));

    page_list_mgr #(.ACT_DEPTH(NA), .SC_DEPTH(0), .PAGE_W(PW)) u_page_list_mgr_fifo (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .res_valid(rv1), .res_code(rc1), .evict_page(ev1));

    // reference state: index 0 is the front of each list
    int act0[$];
    int sc0[$];
    int act1[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0: return "R2 hit";
            1: return "R5 refill";
            2: return "R3 page-in";
            default: return "R6 evict";
        endcase
    endfunction

    // model with a second-chance list
    task automatic step_main(input int p, output int code, output int ev);
        int k;
        int d;
        ev = 0;
        foreach (act0[i]) if (act0[i] == p) begin code = 0; return; end
        k = -1;
        foreach (sc0[i]) if (sc0[i] == p) k = i;
        if (k >= 0) begin
            sc0.delete(k);
            if (act0.size() == NA) begin d = act0.pop_back(); sc0.push_front(d); end
            act0.push_front(p);
            code = 1;
            return;
        end
        if (act0.size() < NA) begin
            act0.push_front(p);
            code = 2;
            return;
        end
        d = act0.pop_back();
        if (sc0.size() == NS) begin ev = sc0.pop_back(); code = 3; end
        else code = 2;
        sc0.push_front(d);
        act0.push_front(p);
    endtask

    // model with no second-chance list: plain FIFO
    task automatic step_fifo(input int p, output int code, output int ev);
        ev = 0;
        foreach (act1[i]) if (act1[i] == p) begin code = 0; return; end
        if (act1.size() < NA) begin act1.push_front(p); code = 2; return; end
        ev = act1.pop_back();
        act1.push_front(p);
        code = 3;
    endtask

    // one cycle: drive at negedge, compare results at the next negedge
    task automatic cycle(input bit v, input int p, input int want_code);
        int c0, e0, c1, e1;
        acc_valid = v;
        acc_page  = p[PW-1:0];
        c0 = 0; e0 = 0; c1 = 0; e1 = 0;
        if (v) begin
            step_main(p, c0, e0);
            step_fifo(p, c1, e1);
        end
        @(negedge clk);
        if (v) begin
            check(rv0 == 1'b1, "R9 result valid", int'(rv0), 1);
            check(int'(rc0) == c0, tag_of(c0), int'(rc0), c0);
            check(int'(ev0) == e0, "R6 evict page", int'(ev0), e0);
            check(rv1 == 1'b1, "R10 result valid", int'(rv1), 1);
            check(int'(rc1) == c1, "R10 fifo code", int'(rc1), c1);
            check(int'(ev1) == e1, "R10 fifo evict page", int'(ev1), e1);
            if (want_code >= 0)
                check(int'(rc0) == want_code, "directed code", int'(rc0), want_code);
        end else begin
            check(rv0 == 1'b0, "R9 idle result", int'(rv0), 0);
            check(ev0 == '0, "R6 idle evict zero", int'(ev0), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(rv0 == 1'b0 && rv1 == 1'b0, "R1 reset res_valid", int'(rv0), 0);
        check(ev0 == '0, "R1 reset evict_page", int'(ev0), 0);
        act0.delete(); sc0.delete(); act1.delete();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 / R3: fill the active list
        cycle(1, 1, 2); cycle(1, 2, 2); cycle(1, 3, 2); cycle(1, 4, 2);
        // R2: hit leaves order alone (checked later by eviction order)
        cycle(1, 1, 0);
        cycle(0, 0, -1);
        // R4: overflows demote 1, 2, 3 into the second-chance list
        cycle(1, 5, 2); cycle(1, 6, 2); cycle(1, 7, 2);
        // R5: refill page 1 while active is full (remove + push same cycle)
        cycle(1, 1, 1);
        cycle(1, 1, 0);
        // R6 / R7: miss with both lists full evicts the least recently demoted
        cycle(1, 8, 3);
        // R7: refill from the middle, then force evictions in order
        cycle(1, 4, 1);
        cycle(1, 9, 3); cycle(1, 10, 3); cycle(1, 11, 3);
        // R8: refilled page must now hit, never refill again
        cycle(1, 4, 0);
        // mixed traffic with idle gaps
        for (int n = 0; n < 600; n++) begin
            int p;
            p = $urandom_range(0, 11);
            if ($urandom_range(0, 4) == 0) cycle(0, 0, -1);
            else cycle(1, p, -1);
        end
        // R1: reset mid-run, previously resident page comes back as page-in
        do_reset();
        cycle(1, 4, 2);
        for (int n = 0; n < 200; n++) cycle(1, $urandom_range(0, 6), -1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule